// File: doc/BRIEF.md
# Configurable Macrocell Storage Stage

This block is one storage stage of a programmable-logic fabric. It takes the single sum-of-products bit produced upstream and drives one bit toward the routing network. Static configuration inputs choose four things: whether the bit passes straight through or goes through the storage element, the kind of storage (edge-triggered data, edge-triggered toggle, or level-sensitive latch), where the storage clock comes from, and which initialization terms preset or clear the stored bit.

The block has two operating modes. In shared mode, the clock is one of the block-wide clocks and the preset and clear come from the two initialization terms shared by the whole logic block. In private mode, the clock is either a dedicated per-cell clock term or one of the first two block clocks, and a single per-cell initialization term is used. A swap control decides whether each initialization term presets or clears the bit.

The whole stage runs on a fast system clock `clk`. Every candidate clock source is treated as a sampled level. A rising edge of the selected source is the sample at which it is high after a sample at which it was low. Preset, clear and latch transparency are sampled levels as well. Any change to the stored bit shows on `q_o` after the next `clk` edge. An active-low power-up reset clears the stored bit asynchronously.

Top module: `mc_macrocell`

## Requirements
- R1: While `pwr_rst_n` is low the stored bit is 0 at once. After release, a selected clock source that is already high is not taken as a rising edge until it has been sampled low.
- R2: With `cfg_store_i` = 0 (data type), the stored bit takes `sum_i` at each rising edge of the selected clock source and holds it otherwise. The new value is visible on `q_o` after that `clk` edge.
- R3: With `cfg_store_i` = 1 (toggle type), the stored bit inverts at a rising edge when `sum_i` is 1 and holds when `sum_i` is 0.
- R4: With `cfg_store_i` = 2 (latch type), the stored bit follows `sum_i` at every `clk` edge where the selected source is high, and holds while that source is low.
- R5: With `cfg_comb_i` = 1, `q_o` equals `sum_i` in the same cycle. The storage element keeps updating underneath and its value reappears when `cfg_comb_i` returns to 0.
- R6: In shared mode (`cfg_async_mode_i` = 0), `cfg_clk_sel_i` = k selects `blk_clk_i[k]` and the other block clocks have no effect.
- R7: In private mode, `cfg_clk_sel_i` = 0 selects `pt_clk_i`, 1 selects `blk_clk_i[0]`, and 2 or 3 select `blk_clk_i[1]`. `blk_clk_i[2]` and `blk_clk_i[3]` have no effect.
- R8: In shared mode with `cfg_init_swap_i` = 0, `blk_init_a_i` presets the bit to 1 and `blk_init_b_i` clears it to 0. `pt_init_i` has no effect.
- R9: In private mode, `pt_init_i` clears the bit when `cfg_init_swap_i` = 0 and presets it when it is 1. The two shared initialization terms have no effect.
- R10: In shared mode with `cfg_init_swap_i` = 1, `blk_init_a_i` clears and `blk_init_b_i` presets.
- R11: Clear wins over preset, and both win over any clocked or latch update in the same cycle.
- R12: The unused storage code `cfg_store_i` = 3 behaves exactly like the data type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| pwr_rst_n | input | 1 | Active-low power-up reset, clears the stored bit |
| sum_i | input | 1 | Sum-of-products logic input |
| blk_clk_i | input | BLK_CLKS (4) | Block-wide clock sources |
| pt_clk_i | input | 1 | Per-cell clock product term |
| blk_init_a_i | input | 1 | Shared initialization term, presets unless swapped |
| blk_init_b_i | input | 1 | Shared initialization term, clears unless swapped |
| pt_init_i | input | 1 | Per-cell initialization product term |
| cfg_async_mode_i | input | 1 | 0 = shared mode, 1 = private mode |
| cfg_comb_i | input | 1 | 1 = bypass the storage element |
| cfg_store_i | input | 2 | Storage type: 0 data, 1 toggle, 2 latch, 3 as data |
| cfg_clk_sel_i | input | SEL_W (2) | Clock source select |
| cfg_init_swap_i | input | 1 | Exchange the preset and clear roles |
| q_o | output | 1 | Cell output toward the routing network |

## Verification
A reference model in the bench follows every cycle. The data type is run with the clock held high while the input changes, which separates edge capture from level capture. The same input sequence under the toggle and latch types shows the three storage behaviours apart. Pulses on unselected block clocks, in both modes, show whether the select decode leaks. Overlapping preset, clear and clock edges, each with and without swap and in each mode, pin down both the priority order and the initialization routing.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        ST_DATA   = 2'd0,
        ST_TOGGLE = 2'd1,
        ST_LATCH  = 2'd2,
        ST_SPARE  = 2'd3
    } store_e;

    typedef struct packed {
        logic prev_lvl;
    } clk_state_t;

    typedef struct packed {
        logic bit_v;
    } store_state_t;

endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
    parameter int BLK_CLKS = 4,
    parameter int SEL_W    = $clog2(BLK_CLKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                async_mode_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [BLK_CLKS-1:0] blk_clk_i,
    input  logic                pt_clk_i,
    output logic                lvl_o,
    output logic                rise_o
);
    import mc_pkg::*;

    clk_state_t st_d, st_q;
    logic       lvl;

    always_comb begin
        lvl = 1'b0;
        if (async_mode_i) begin
            if (sel_i == '0)
                lvl = pt_clk_i;
            else if (int'(sel_i) == 1)
                lvl = blk_clk_i[0];
            else
                lvl = blk_clk_i[1];
        end else begin
            for (int k = 0; k < BLK_CLKS; k++) begin
                if (int'(sel_i) == k)
                    lvl = blk_clk_i[k];
            end
        end
        st_d          = st_q;
        st_d.prev_lvl = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.prev_lvl <= 1'b1;
        else
            st_q <= st_d;
    end

    assign lvl_o  = lvl;
    assign rise_o = lvl & ~st_q.prev_lvl;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/mc_init_sel.sv
module mc_init_sel (
    input  logic async_mode_i,
    input  logic swap_i,
    input  logic blk_a_i,
    input  logic blk_b_i,
    input  logic pt_init_i,
    output logic preset_o,
    output logic clear_o
);
    logic set_src_d, clr_src_d;

    always_comb begin
        if (async_mode_i) begin
            set_src_d = swap_i ? pt_init_i : 1'b0;
            clr_src_d = swap_i ? 1'b0 : pt_init_i;
        end else begin
            set_src_d = swap_i ? blk_b_i : blk_a_i;
            clr_src_d = swap_i ? blk_a_i : blk_b_i;
        end
    end

    assign preset_o = set_src_d;
    assign clear_o  = clr_src_d;

endmodule

// File: rtl/mc_store.sv
module mc_store (
    input  logic              clk,
    input  logic              rst_n,
    input  mc_pkg::store_e    store_i,
    input  logic              d_i,
    input  logic              lvl_i,
    input  logic              rise_i,
    input  logic              preset_i,
    input  logic              clear_i,
    output logic              state_o
);
    import mc_pkg::*;

    store_state_t st_d, st_q;
    logic         edge_type;

    assign edge_type = (store_i == ST_DATA) || (store_i == ST_SPARE);

    always_comb begin
        st_d = st_q;
        if (clear_i)
            st_d.bit_v = 1'b0;
        else if (preset_i)
            st_d.bit_v = 1'b1;
        else begin
            unique case (store_i)
                ST_TOGGLE: if (rise_i && d_i) st_d.bit_v = ~st_q.bit_v;
                ST_LATCH:  if (lvl_i)         st_d.bit_v = d_i;
                default:   if (rise_i)        st_d.bit_v = d_i;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign state_o = st_q.bit_v;

    // R11
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state_o == 1'b0));

    // R11
    preset_over_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_i && !clear_i) |=> state_o);

    // R2
    data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_i && !clear_i && rise_i && edge_type) |=> (state_o == $past(d_i)));

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_i && !clear_i && rise_i && d_i && store_i == ST_TOGGLE)
            |=> (state_o != $past(state_o)));

    // R4
    closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_i && !clear_i && !lvl_i) |=> $stable(state_o));

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell #(
    parameter  int BLK_CLKS = 4,
    localparam int SEL_W    = $clog2(BLK_CLKS)
) (
    input  logic                clk,
    input  logic                pwr_rst_n,
    input  logic                sum_i,
    input  logic [BLK_CLKS-1:0] blk_clk_i,
    input  logic                pt_clk_i,
    input  logic                blk_init_a_i,
    input  logic                blk_init_b_i,
    input  logic                pt_init_i,
    input  logic                cfg_async_mode_i,
    input  logic                cfg_comb_i,
    input  logic [1:0]          cfg_store_i,
    input  logic [SEL_W-1:0]    cfg_clk_sel_i,
    input  logic                cfg_init_swap_i,
    output logic                q_o
);
    import mc_pkg::*;

    logic sel_lvl, sel_rise;
    logic do_preset, do_clear;
    logic held_bit;
    logic out_d;

    mc_clk_sel #(.BLK_CLKS(BLK_CLKS), .SEL_W(SEL_W)) u_clk_sel (
        .clk          (clk),
        .rst_n        (pwr_rst_n),
        .async_mode_i (cfg_async_mode_i),
        .sel_i        (cfg_clk_sel_i),
        .blk_clk_i    (blk_clk_i),
        .pt_clk_i     (pt_clk_i),
        .lvl_o        (sel_lvl),
        .rise_o       (sel_rise)
    );

    mc_init_sel u_init_sel (
        .async_mode_i (cfg_async_mode_i),
        .swap_i       (cfg_init_swap_i),
        .blk_a_i      (blk_init_a_i),
        .blk_b_i      (blk_init_b_i),
        .pt_init_i    (pt_init_i),
        .preset_o     (do_preset),
        .clear_o      (do_clear)
    );

    mc_store u_store (
        .clk      (clk),
        .rst_n    (pwr_rst_n),
        .store_i  (store_e'(cfg_store_i)),
        .d_i      (sum_i),
        .lvl_i    (sel_lvl),
        .rise_i   (sel_rise),
        .preset_i (do_preset),
        .clear_i  (do_clear),
        .state_o  (held_bit)
    );

    always_comb begin
        out_d = held_bit;
        if (cfg_comb_i)
            out_d = sum_i;
    end

    assign q_o = out_d;

    // R9
    private_single_init_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        cfg_async_mode_i |-> !(do_preset && do_clear));

    // R1
    powerup_clear_chk: assert property (@(posedge clk)
        (!pwr_rst_n && !cfg_comb_i) |-> (q_o == 1'b0));

endmodule

// File: tb/mc_macrocell_bench.sv
module mc_macrocell_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       pwr_rst_n = 1'b0;
    logic       sum_i = 1'b0;
    logic [3:0] blk_clk_i = '0;
    logic       pt_clk_i = 1'b0;
    logic       blk_init_a_i = 1'b0;
    logic       blk_init_b_i = 1'b0;
    logic       pt_init_i = 1'b0;
    logic       cfg_async_mode_i = 1'b0;
    logic       cfg_comb_i = 1'b0;
    logic [1:0] cfg_store_i = 2'd0;
    logic [1:0] cfg_clk_sel_i = 2'd0;
    logic       cfg_init_swap_i = 1'b0;
    logic       q_o;

    // staged values, copied to the DUT at a falling edge
    logic       s_rst_n = 1'b1, s_sum = 1'b0, s_pt_clk = 1'b0;
    logic [3:0] s_blk = '0;
    logic       s_ia = 1'b0, s_ib = 1'b0, s_pti = 1'b0;
    logic       s_async = 1'b0, s_comb = 1'b0, s_swap = 1'b0;
    logic [1:0] s_store = 2'd0, s_sel = 2'd0;

    logic  m_q = 1'b0, m_prev = 1'b1;
    item_t sb[$];
    int    checks = 0, failures = 0;
    bit    done = 1'b0;

    mc_macrocell u_mc_macrocell (
        .clk (clk), .pwr_rst_n (pwr_rst_n), .sum_i (sum_i),
        .blk_clk_i (blk_clk_i), .pt_clk_i (pt_clk_i),
        .blk_init_a_i (blk_init_a_i), .blk_init_b_i (blk_init_b_i),
        .pt_init_i (pt_init_i), .cfg_async_mode_i (cfg_async_mode_i),
        .cfg_comb_i (cfg_comb_i), .cfg_store_i (cfg_store_i),
        .cfg_clk_sel_i (cfg_clk_sel_i), .cfg_init_swap_i (cfg_init_swap_i),
        .q_o (q_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input string tag);
        logic lvl, rise, pre, clr;
        item_t it;
        @(negedge clk);
        pwr_rst_n = s_rst_n; sum_i = s_sum; blk_clk_i = s_blk; pt_clk_i = s_pt_clk;
        blk_init_a_i = s_ia; blk_init_b_i = s_ib; pt_init_i = s_pti;
        cfg_async_mode_i = s_async; cfg_comb_i = s_comb; cfg_store_i = s_store;
        cfg_clk_sel_i = s_sel; cfg_init_swap_i = s_swap;
        if (s_async)
            lvl = (s_sel == 2'd0) ? s_pt_clk : (s_sel == 2'd1) ? s_blk[0] : s_blk[1];
        else
            lvl = s_blk[s_sel];
        rise = lvl && !m_prev;
        if (s_async) begin
            pre = s_swap & s_pti;
            clr = ~s_swap & s_pti;
        end else begin
            pre = s_swap ? s_ib : s_ia;
            clr = s_swap ? s_ia : s_ib;
        end
        if (!s_rst_n) begin
            m_q = 1'b0; m_prev = 1'b1;
        end else begin
            if (clr) m_q = 1'b0;
            else if (pre) m_q = 1'b1;
            else if (s_store == 2'd1) begin
                if (rise && s_sum) m_q = ~m_q;
            end else if (s_store == 2'd2) begin
                if (lvl) m_q = s_sum;
            end else if (rise) m_q = s_sum;
            m_prev = lvl;
        end
        it.exp = s_comb ? s_sum : m_q;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic pulse_blk(input int idx, input string tag);
        s_blk[idx] = 1'b1; tick(tag);
        s_blk[idx] = 1'b0; tick(tag);
    endtask

    // monitor: compares after each rising edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (q_o !== it.exp) begin
                    failures++;
                    $display("FAIL %s q_o actual=%b expected=%b", it.tag, q_o, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #2;
        checks++;
        if (q_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 q_o actual=%b expected=0", q_o);
        end
        s_rst_n = 1'b0; tick("R1");
        s_rst_n = 1'b1; s_blk[0] = 1'b1; tick("R1 high at release");
        s_sum = 1'b1; tick("R1 no edge while held high");

        // R2 data type, shared clock 0
        s_blk[0] = 1'b0; tick("R2 clock low hold");
        s_blk[0] = 1'b1; tick("R2 capture");
        s_sum = 1'b0; tick("R2 level high no capture");
        s_blk[0] = 1'b0; tick("R2 low");
        s_blk[0] = 1'b1; tick("R2 capture 0");
        s_blk[0] = 1'b0; tick("R2");

        // R6 shared select
        s_sel = 2'd2; s_sum = 1'b1;
        pulse_blk(0, "R6 unselected clk0");
        pulse_blk(3, "R6 unselected clk3");
        pulse_blk(2, "R6 selected clk2");
        s_sum = 1'b0; s_sel = 2'd3;
        pulse_blk(3, "R6 selected clk3");

        // R3 toggle
        s_store = 2'd1; s_sel = 2'd2; s_sum = 1'b1;
        pulse_blk(2, "R3 toggle 1");
        pulse_blk(2, "R3 toggle 2");
        pulse_blk(2, "R3 toggle 3");
        s_sum = 1'b0;
        pulse_blk(2, "R3 hold on 0");

        // R4 latch
        s_store = 2'd2; s_sel = 2'd0; s_blk[0] = 1'b1;
        s_sum = 1'b0; tick("R4 follow 0");
        s_sum = 1'b1; tick("R4 follow 1");
        s_sum = 1'b0; tick("R4 follow 0b");
        s_sum = 1'b1; tick("R4 follow 1b");
        s_blk[0] = 1'b0; s_sum = 1'b0; tick("R4 closed");
        s_sum = 1'b1; tick("R4 closed 1");
        s_sum = 1'b0; tick("R4 closed 0");

        // R5 combinational bypass
        s_comb = 1'b1; s_sum = 1'b0; tick("R5 bypass 0");
        s_sum = 1'b1; tick("R5 bypass 1");
        s_sum = 1'b0; tick("R5 bypass 0b");
        s_comb = 1'b0; tick("R5 stored returns");
        s_comb = 1'b1; s_store = 2'd0; s_sum = 1'b0;
        pulse_blk(0, "R5 storage updates underneath");
        s_comb = 1'b0; s_sum = 1'b1; tick("R5 stored 0 visible");

        // R8 shared init
        s_ia = 1'b1; tick("R8 preset");
        s_ia = 1'b0; s_ib = 1'b1; tick("R8 clear");
        s_ib = 1'b0; s_pti = 1'b1; tick("R8 pt_init ignored");
        s_pti = 1'b0; s_ia = 1'b1; tick("R8 preset again");
        s_ia = 1'b0;

        // R10 swap
        s_swap = 1'b1; s_ia = 1'b1; tick("R10 a clears");
        s_ia = 1'b0; s_ib = 1'b1; tick("R10 b presets");
        s_ib = 1'b0; s_swap = 1'b0;

        // R11 priority
        s_ia = 1'b1; s_ib = 1'b1; tick("R11 clear over preset");
        s_ia = 1'b0; s_ib = 1'b0; tick("R11");
        s_sum = 1'b1; s_ib = 1'b1; s_blk[0] = 1'b1; tick("R11 clear over edge");
        s_blk[0] = 1'b0; s_ib = 1'b0; tick("R11");
        s_sum = 1'b0; s_ia = 1'b1; s_blk[0] = 1'b1; tick("R11 preset over edge");
        s_blk[0] = 1'b0; s_ia = 1'b0; tick("R11");

        // R7 / R9 private mode
        s_async = 1'b1; s_sel = 2'd0; s_sum = 1'b0;
        s_pt_clk = 1'b1; tick("R7 pt clock");
        s_pt_clk = 1'b0; tick("R7");
        s_sum = 1'b1; s_ia = 1'b1; tick("R9 shared a ignored");
        s_ia = 1'b0; s_pt_clk = 1'b1; tick("R7 pt clock capture");
        s_pt_clk = 1'b0; s_ib = 1'b1; tick("R9 shared b ignored");
        s_ib = 1'b0; s_pti = 1'b1; tick("R9 pt clears");
        s_swap = 1'b1; tick("R9 pt presets swapped");
        s_pti = 1'b0; s_swap = 1'b0; s_sel = 2'd1; s_sum = 1'b0;
        pulse_blk(1, "R7 clk1 not selected by 1");
        pulse_blk(0, "R7 clk0 selected");
        s_sel = 2'd3; s_sum = 1'b1;
        pulse_blk(2, "R7 clk2 ignored");
        pulse_blk(3, "R7 clk3 ignored");
        pulse_blk(1, "R7 clk1 selected by 3");
        s_sel = 2'd2; s_sum = 1'b0;
        pulse_blk(1, "R7 clk1 selected by 2");

        // R12 spare code acts as data
        s_async = 1'b0; s_sel = 2'd0; s_store = 2'd3;
        s_ia = 1'b1; tick("R12 setup"); s_ia = 1'b0;
        s_sum = 1'b1; pulse_blk(0, "R12 keeps 1 like data");
        s_sum = 1'b0; pulse_blk(0, "R12 loads 0");

        // R1 power-up reset mid-run
        s_sum = 1'b1; pulse_blk(0, "R1 setup");
        s_rst_n = 1'b0; tick("R1 reset clears");
        s_rst_n = 1'b1; tick("R1 after release");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule